// File: doc/BRIEF.md
# Strobe-Held Binary to One-Hot Select Decoder

This block turns a four-bit binary code into a sixteen-wire select vector with exactly one wire active. The code does not go straight to the decoder. It passes through a hold register that loads on each rising clock edge while `strobe` is high. While `strobe` is low the register keeps its last value, so the code bus can be reused for other traffic and the selected wire does not move. The hold register is the synchronous form of a transparent latch.

The `inhibit` input blanks the whole vector at once. It acts on the decode stage without a clock, and it is never stored in the hold register. A compile-time parameter sets the polarity of the output. In the active-high form the chosen wire is 1 and the others are 0. In the active-low form every bit is inverted. A typical use is to steer a serial bit to one of sixteen destinations: the destination address sits in the hold register and the data bit drives `inhibit`.

Top module: `latched_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the held code to 0. With `inhibit` low, the following cycle shows output bit 0 active.
- R2: At a rising edge with `strobe` high and `rst` low, the held code takes the value of `code_in`. From that edge on, the output reflects the new code.
- R3: At a rising edge with `strobe` low, the held code does not change. Any change on `code_in` has no effect on `sel_out` until `strobe` is sampled high again.
- R4: `code_in[3]` is the most significant bit and `code_in[0]` the least. A held code of value n activates `sel_out[n]`, so 0 selects bit 0 and 15 selects bit 15.
- R5: With `inhibit` low, exactly one bit of the output is at the active level.
- R6: With `inhibit` high, every output bit is at the inactive level in the same cycle, whatever the held code.
- R7: `inhibit` is not stored. A code loaded while `inhibit` is high appears on the output as soon as `inhibit` goes low, with no further strobe.
- R8: With the active-low setting (`POLARITY = POL_LOW`), the output is the exact bitwise inverse of the active-high output for the same inputs. Inactive is 1 and active is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the hold register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the held code |
| strobe | input | 1 | Load enable for the hold register |
| inhibit | input | 1 | Blanks all outputs, combinational, not stored |
| code_in | input | CODE_W (4) | Binary select code, bit 3 most significant |
| sel_out | output | 2**CODE_W (16) | One-hot select vector in the chosen polarity |

## Verification
The only internal state is the held code. A wrong value there shows up at once as the wrong wire being active. It appears in the first cycle after the faulty load, or after the faulty failure to load, unless `inhibit` hides it; an error masked that way shows the cycle `inhibit` drops. To expose such errors, the bench changes `code_in` while `strobe` is low and loads codes while `inhibit` is high. It compares the output against a behavioural model on every clock. The inhibit path has no state, so a fault there appears in the same cycle as the `inhibit` change.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} polarity_e;
endpackage

// File: rtl/code_hold.sv
module code_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/onehot_decode.sv
module onehot_decode #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code,
  input  logic         blank,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot[i] = !blank && (code == W'(i));
  end
endmodule

// File: rtl/polarity_stage.sv
module polarity_stage
  import latdec_pkg::*;
#(
  parameter int        N   = 16,
  parameter polarity_e POL = POL_HIGH
) (
  input  logic [N-1:0] a,
  output logic [N-1:0] y
);
  if (POL == POL_LOW) begin : g_low
    assign y = ~a;
  end else begin : g_high
    assign y = a;
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder
  import latdec_pkg::*;
#(
  parameter int        CODE_W   = 4,
  parameter polarity_e POLARITY = POL_HIGH,
  localparam int       OUT_N    = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              inhibit,
  input  logic [CODE_W-1:0] code_in,
  output logic [OUT_N-1:0]  sel_out
);
  logic [CODE_W-1:0] held_code;
  logic [OUT_N-1:0]  hot_vec;

  code_hold #(.W(CODE_W)) u_hold (
    .clk (clk),
    .rst (rst),
    .load(strobe),
    .d   (code_in),
    .q   (held_code)
  );

  onehot_decode #(.W(CODE_W)) u_dec (
    .code (held_code),
    .blank(inhibit),
    .hot  (hot_vec)
  );

  polarity_stage #(.N(OUT_N), .POL(POLARITY)) u_pol (
    .a(hot_vec),
    .y(sel_out)
  );
endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk
  import latdec_pkg::*;
#(
  parameter int        CODE_W   = 4,
  parameter polarity_e POLARITY = POL_HIGH,
  localparam int       OUT_N    = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              inhibit,
  input logic [CODE_W-1:0] code_in,
  input logic [OUT_N-1:0]  sel_out
);
  logic [OUT_N-1:0] norm;
  assign norm = (POLARITY == POL_LOW) ? ~sel_out : sel_out;

  // R1: after a reset edge bit 0 is selected unless blanked
  assert_reset_sel0_R1: assert property (@(posedge clk)
    rst |=> (inhibit || norm == OUT_N'(1)));

  // R2 / R4: a strobed code shows up as its own bit on the next cycle
  assert_load_code_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (inhibit || norm == (OUT_N'(1) << $past(code_in))));

  // R3: strobe low keeps the output frozen while unblanked
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !inhibit) |=> (inhibit || $stable(sel_out)));

  // R5: exactly one active bit when not inhibited
  assert_single_active_R5: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> $countones(norm) == 1);

  // R6: inhibit blanks every bit
  assert_inhibit_blank_R6: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> norm == '0);
endmodule

bind latched_decoder latched_decoder_chk #(
  .CODE_W  (CODE_W),
  .POLARITY(POLARITY)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .strobe (strobe),
  .inhibit(inhibit),
  .code_in(code_in),
  .sel_out(sel_out)
);

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;
  import latdec_pkg::*;
  localparam int CW = 4;
  localparam int NO = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobe = 1'b0;
  logic          inhibit = 1'b0;
  logic [CW-1:0] code_in = '0;
  logic [NO-1:0] out_hi, out_lo;

  int vectors = 0;
  int errors = 0;
  int ref_code = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  latched_decoder #(.CODE_W(CW), .POLARITY(POL_HIGH)) u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit),
    .code_in(code_in), .sel_out(out_hi));

  latched_decoder #(.CODE_W(CW), .POLARITY(POL_LOW)) u_dut_lo (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit),
    .code_in(code_in), .sel_out(out_lo));

  task automatic check(input bit ok, input string req,
                       input logic [NO-1:0] act, input logic [NO-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: held value updated at each edge
  always @(posedge clk) begin
    if (rst)         ref_code = 0;
    else if (strobe) ref_code = int'(code_in);
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NO-1:0] exp;
      exp = inhibit ? '0 : (NO'(1) << ref_code);
      check(out_hi == exp, phase, out_hi, exp);
      check(out_lo == ~exp, "R8", out_lo, ~exp);
      if (!inhibit)
        check($countones(out_hi) == 1, "R5", out_hi, exp);
    end
  end

  task automatic step(input bit s, input bit inh, input int c);
    @(posedge clk);
    #2;
    strobe  = s;
    inhibit = inh;
    code_in = CW'(c);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1: reset state shows bit 0
    @(negedge clk);
    check(out_hi == NO'(1), "R1", out_hi, NO'(1));

    // R2 / R4: every code, inhibit low then high
    phase = "R4";
    for (int c = 0; c < NO; c++) begin
      step(1'b1, 1'b0, c);
      step(1'b0, 1'b0, c);
    end
    phase = "R6";
    for (int c = 0; c < NO; c++) step(1'b1, 1'b1, c);

    // R3: data changes with strobe low are ignored
    phase = "R2";
    step(1'b1, 1'b0, 9);
    phase = "R3";
    for (int c = 0; c < NO; c++) step(1'b0, 1'b0, NO - 1 - c);
    @(negedge clk);
    check(out_hi == NO'(1) << 9, "R3", out_hi, NO'(1) << 9);

    // R7: code loaded while blanked appears when inhibit drops
    phase = "R7";
    step(1'b1, 1'b1, 12);
    step(1'b0, 1'b1, 3);
    step(1'b0, 1'b0, 5);
    @(negedge clk);
    check(out_hi == NO'(1) << 12, "R7", out_hi, NO'(1) << 12);

    // R6: inhibit acts in the same cycle without a strobe
    phase = "R6";
    step(1'b0, 1'b1, 5);
    step(1'b0, 1'b0, 5);

    // R1: reset mid-run returns to code 0
    phase = "R1";
    step(1'b0, 1'b0, 7);
    #1 rst = 1'b1;
    @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(out_hi == NO'(1), "R1", out_hi, NO'(1));

    // R2: back-to-back loads
    phase = "R2";
    for (int c = 0; c < NO; c++) step(1'b1, 1'b0, (c * 7) % NO);
    step(1'b0, 1'b0, 0);
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule